// File: doc/BRIEF.md
# Variable-Width Load/Store Execution Unit

This unit carries out the memory load and store instructions of a 16-bit CPU that has an accumulator (A) and two index registers (X, Y). Two status flags set the operand width at run time. The accumulator width follows the memory-width flag. The index width follows the index-width flag. Each flag works on its own register class only.

A decoder upstream hands over a request that is already resolved:
- the operation,
- the addressing mode,
- the 24-bit effective address,
- a page-cross indication,
- the low byte of the direct-page register,
- the two width flags.

The unit then runs one or two byte-wide bus beats. Loads update the target register and the N and Z flags. When the unit pulses `done`, it also reports how many extra cycles the instruction costs.

The unit holds the three registers and the N/Z flags. Their values are visible as outputs. Only loads change them. A store reads its source from these registers. The store-zero operation writes zero bytes.

Top module: `ldst_unit`

## Requirements
- R1: A-class operations (load A = 0, store A = 3, store zero = 6 on `reqOp`) make one bus beat when `flagM` = 1 and two beats when `flagM` = 0. The value of `flagX` has no effect on them.
- R2: X/Y operations (load X = 1, load Y = 2, store X = 4, store Y = 5) make one beat when `flagX` = 1 and two beats when `flagX` = 0. The value of `flagM` has no effect on them.
- R3: A two-byte transfer moves the low byte at the effective address in the first beat. It moves the high byte at the effective address plus one, modulo 2^24, in the very next cycle.
- R4: Store zero writes 0x00 on every beat it makes. A store of A, X or Y writes the low byte and then the high byte of the source register.
- R5: The extra-cycle count is 1 for a two-byte access and 0 for a one-byte access, before any penalty is added.
- R6: A load of any register, and a store of A, adds 1 when the mode is direct-page based (`reqMode` 5 to 12) and `dpLow` is nonzero.
- R7: Load A in mode 1 (absolute + X) or mode 2 (absolute + Y) adds 1 when `pageCross` = 1. Load X and load Y add 1 for `pageCross` only in mode 2. No other case adds anything for `pageCross`.
- R8: Store X and store Y add the nonzero-`dpLow` penalty in every mode except 0 (absolute). Store zero adds it in every mode except 0 and 1.
- R9: After a load, Z is 1 exactly when the loaded register is zero at its active width (low byte for one-byte, all 16 bits for two-byte).
- R10: After a load, N equals bit 7 (one-byte) or bit 15 (two-byte) of the loaded register.
- R11: A one-byte load replaces only bits 7:0 of the target register. Bits 15:8 keep their previous value.
- R12: `done` pulses for one cycle, in the cycle after the last beat, with `extraCycles` valid. `reqReady` is 1 only when idle. A request presented while busy starts no beat and changes nothing.
- R13: Stores leave A, X, Y, N and Z unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present; taken only while `reqReady` is 1 |
| reqOp | input | 3 | Operation: 0 LDA, 1 LDX, 2 LDY, 3 STA, 4 STX, 5 STY, 6 STZ, 7 ignored |
| reqMode | input | 4 | Resolved addressing mode |
| reqAddr | input | 24 | Effective address |
| pageCross | input | 1 | Indexing crossed a page boundary |
| dpLow | input | 8 | Low byte of the direct-page register |
| flagM | input | 1 | 1 = accumulator is one byte wide |
| flagX | input | 1 | 1 = index registers are one byte wide |
| reqReady | output | 1 | Unit idle, can take a request |
| memAddr | output | 24 | Bus address of the current beat |
| memRead | output | 1 | Read beat this cycle |
| memWrite | output | 1 | Write beat this cycle |
| memWdata | output | 8 | Write data byte |
| memRdata | input | 8 | Read data byte, valid in the cycle of the read beat |
| done | output | 1 | Instruction finished |
| extraCycles | output | 2 | Extra-cycle count, valid with `done` |
| regA | output | 16 | Accumulator |
| regX | output | 16 | X index register |
| regY | output | 16 | Y index register |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |

## Verification
The assertions assume that memory answers a read beat in the same cycle, without wait states. They also assume that `reqOp` values other than the seven defined operations are never sent as real work. The bench models memory as a combinational byte array indexed by the low address byte. It keeps every request inside the defined operation codes. It changes request fields only on the falling clock edge, and holds `reqValid` while busy only in the deliberate busy-request scenario.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [2:0] {
    OP_LDA = 3'd0,
    OP_LDX = 3'd1,
    OP_LDY = 3'd2,
    OP_STA = 3'd3,
    OP_STX = 3'd4,
    OP_STY = 3'd5,
    OP_STZ = 3'd6,
    OP_NOP = 3'd7
  } ldstOp_e;

  typedef enum logic [3:0] {
    AM_ABS       = 4'd0,
    AM_ABS_X     = 4'd1,
    AM_ABS_Y     = 4'd2,
    AM_LONG      = 4'd3,
    AM_LONG_X    = 4'd4,
    AM_DP        = 4'd5,
    AM_DP_IND    = 4'd6,
    AM_DP_IND_L  = 4'd7,
    AM_DP_X      = 4'd8,
    AM_DP_Y      = 4'd9,
    AM_DP_X_IND  = 4'd10,
    AM_DP_IND_Y  = 4'd11,
    AM_DP_IL_Y   = 4'd12,
    AM_STK       = 4'd13,
    AM_STK_IND_Y = 4'd14,
    AM_OTHER     = 4'd15
  } addrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      accept;
    logic      rd;
    logic      wr;
    logic      hiBeat;
    logic      commit;
    logic      fin;
    logic      wide;
    ldstOp_e   op;
  } ctrlStrobe_t;

  function automatic logic isLoad(ldstOp_e op);
    return (op == OP_LDA) || (op == OP_LDX) || (op == OP_LDY);
  endfunction

  function automatic logic isAccClass(ldstOp_e op);
    return (op == OP_LDA) || (op == OP_STA) || (op == OP_STZ);
  endfunction

  function automatic logic isDpMode(addrMode_e mode);
    return (mode >= AM_DP) && (mode <= AM_DP_IL_Y);
  endfunction

endpackage

// File: rtl/ldst_cost.sv
module ldst_cost
  import ldst_pkg::*;
(
  input  ldstOp_e   op,
  input  addrMode_e mode,
  input  logic      wide,
  input  logic      dpNz,
  input  logic      pageCross,
  output logic [1:0] cost
);

  logic dpApplies;
  logic pcApplies;

  always_comb begin
    dpApplies = 1'b0;
    pcApplies = 1'b0;
    unique case (op)
      OP_LDA: begin
        dpApplies = isDpMode(mode);
        pcApplies = (mode == AM_ABS_X) || (mode == AM_ABS_Y);
      end
      OP_LDX, OP_LDY: begin
        dpApplies = isDpMode(mode);
        pcApplies = (mode == AM_ABS_Y);
      end
      OP_STA:         dpApplies = isDpMode(mode);
      OP_STX, OP_STY: dpApplies = (mode != AM_ABS);
      OP_STZ:         dpApplies = (mode != AM_ABS) && (mode != AM_ABS_X);
      default: ;
    endcase
  end

  assign cost = {1'b0, wide} + {1'b0, dpApplies & dpNz} + {1'b0, pcApplies & pageCross};

endmodule

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  ldstOp_e     reqOp,
  input  logic        flagM,
  input  logic        flagX,
  output logic        reqReady,
  output ctrlStrobe_t ctrlS
);

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_FIN} state_e;

  state_e  state;
  ldstOp_e opQ;
  logic    wideQ;
  logic    take;
  logic    wideNext;

  assign reqReady = (state == S_IDLE);
  assign take     = reqReady && reqValid && (reqOp != OP_NOP);
  assign wideNext = isAccClass(reqOp) ? !flagM : !flagX;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      opQ   <= OP_NOP;
      wideQ <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (take) begin
          state <= S_LO;
          opQ   <= reqOp;
          wideQ <= wideNext;
        end
        S_LO:   state <= wideQ ? S_HI : S_FIN;
        S_HI:   state <= S_FIN;
        S_FIN:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrlS.accept = take;
    ctrlS.rd     = ((state == S_LO) || (state == S_HI)) && isLoad(opQ);
    ctrlS.wr     = ((state == S_LO) || (state == S_HI)) && !isLoad(opQ);
    ctrlS.hiBeat = (state == S_HI);
    ctrlS.commit = ((state == S_LO) && !wideQ) || (state == S_HI);
    ctrlS.fin    = (state == S_FIN);
    ctrlS.wide   = wideQ;
    ctrlS.op     = opQ;
  end

endmodule

// File: rtl/ldst_datapath.sv
module ldst_datapath
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       ctrlS,
  input  addrMode_e         reqMode,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              pageCross,
  input  logic [7:0]        dpLow,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [REG_W-1:0]  regA,
  output logic [REG_W-1:0]  regX,
  output logic [REG_W-1:0]  regY,
  output logic              flagN,
  output logic              flagZ,
  output logic              done,
  output logic [1:0]        extraCycles
);

  localparam int NUM_REGS = 3;
  localparam int BYTE_W   = 8;

  logic [ADDR_W-1:0] addrQ;
  addrMode_e         modeQ;
  logic              dpNzQ;
  logic              pcQ;
  logic [BYTE_W-1:0] loByteQ;
  logic [REG_W-1:0]  regFile [NUM_REGS];
  logic [1:0]        destIdx;
  logic [REG_W-1:0]  destOld;
  logic [REG_W-1:0]  srcVal;
  logic [REG_W-1:0]  newVal;
  logic              loadCommit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      modeQ   <= AM_ABS;
      dpNzQ   <= 1'b0;
      pcQ     <= 1'b0;
      loByteQ <= '0;
    end else begin
      if (ctrlS.accept) begin
        addrQ <= reqAddr;
        modeQ <= reqMode;
        dpNzQ <= |dpLow;
        pcQ   <= pageCross;
      end
      if (ctrlS.rd && !ctrlS.hiBeat) loByteQ <= memRdata;
    end
  end

  always_comb begin
    unique case (ctrlS.op)
      OP_LDX, OP_STX: destIdx = 2'd1;
      OP_LDY, OP_STY: destIdx = 2'd2;
      default:        destIdx = 2'd0;
    endcase
    destOld = regFile[destIdx];
    srcVal  = (ctrlS.op == OP_STZ) ? '0 : regFile[destIdx];
    newVal  = ctrlS.wide ? {memRdata, loByteQ} : {destOld[REG_W-1:BYTE_W], memRdata};
  end

  assign loadCommit = ctrlS.commit && isLoad(ctrlS.op);

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN) regFile[g] <= '0;
      else if (loadCommit && (destIdx == 2'(g))) regFile[g] <= newVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagN <= 1'b0;
      flagZ <= 1'b0;
    end else if (loadCommit) begin
      flagN <= ctrlS.wide ? newVal[REG_W-1] : newVal[BYTE_W-1];
      flagZ <= ctrlS.wide ? (newVal == '0) : (newVal[BYTE_W-1:0] == '0);
    end
  end

  ldst_cost costI (
    .op        (ctrlS.op),
    .mode      (modeQ),
    .wide      (ctrlS.wide),
    .dpNz      (dpNzQ),
    .pageCross (pcQ),
    .cost      (extraCycles)
  );

  assign memAddr  = ctrlS.hiBeat ? addrQ + ADDR_W'(1) : addrQ;
  assign memWdata = !ctrlS.wr ? '0 :
                    ctrlS.hiBeat ? srcVal[REG_W-1:BYTE_W] : srcVal[BYTE_W-1:0];
  assign done     = ctrlS.fin;
  assign regA     = regFile[0];
  assign regX     = regFile[1];
  assign regY     = regFile[2];

endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [3:0]        reqMode,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              pageCross,
  input  logic [7:0]        dpLow,
  input  logic              flagM,
  input  logic              flagX,
  output logic              reqReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRead,
  output logic              memWrite,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic              done,
  output logic [1:0]        extraCycles,
  output logic [15:0]       regA,
  output logic [15:0]       regX,
  output logic [15:0]       regY,
  output logic              flagN,
  output logic              flagZ
);

  ctrlStrobe_t ctrlS;

  ldst_ctrl ctrlI (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (ldstOp_e'(reqOp)),
    .flagM    (flagM),
    .flagX    (flagX),
    .reqReady (reqReady),
    .ctrlS    (ctrlS)
  );

  ldst_datapath #(.ADDR_W(ADDR_W), .REG_W(16)) dpI (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlS       (ctrlS),
    .reqMode     (addrMode_e'(reqMode)),
    .reqAddr     (reqAddr),
    .pageCross   (pageCross),
    .dpLow       (dpLow),
    .memRdata    (memRdata),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .regA        (regA),
    .regX        (regX),
    .regY        (regY),
    .flagN       (flagN),
    .flagZ       (flagZ),
    .done        (done),
    .extraCycles (extraCycles)
  );

  assign memRead  = ctrlS.rd;
  assign memWrite = ctrlS.wr;

endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              memRead,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic [7:0]        memWdata,
  input logic              done,
  input logic [15:0]       regA,
  input logic [15:0]       regX,
  input logic [15:0]       regY,
  input logic              flagN,
  input logic              flagZ,
  input ctrlStrobe_t       ctrlS
);

  logic beat;
  assign beat = memRead || memWrite;

  // R12
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(memRead && memWrite));

  // R3
  beat_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beat && $past(beat)) |-> (memAddr == $past(memAddr) + ADDR_W'(1)));

  // R12
  done_after_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(beat) && !beat));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !beat);

  // R4
  zero_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrite && (ctrlS.op == OP_STZ)) |-> (memWdata == 8'h00));

  // R13
  store_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |=> ($stable(regA) && $stable(regX) && $stable(regY) && $stable(flagN) && $stable(flagZ)));

endmodule

bind ldst_unit ldst_unit_chk #(.ADDR_W(ADDR_W)) chkI (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .memRead  (memRead),
  .memWrite (memWrite),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .done     (done),
  .regA     (regA),
  .regX     (regX),
  .regY     (regY),
  .flagN    (flagN),
  .flagZ    (flagZ),
  .ctrlS    (ctrlS)
);

// File: tb/ldst_unit_test.sv
module ldst_unit_test;

  localparam logic [2:0] LDA = 3'd0, LDX = 3'd1, LDY = 3'd2, STA = 3'd3,
                         STX = 3'd4, STY = 3'd5, STZ = 3'd6;
  localparam logic [3:0] M_ABS = 4'd0, M_ABS_X = 4'd1, M_ABS_Y = 4'd2,
                         M_DP = 4'd5, M_DP_Y = 4'd9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = 3'd0;
  logic [3:0]  reqMode = 4'd0;
  logic [23:0] reqAddr = '0;
  logic        pageCross = 1'b0;
  logic [7:0]  dpLow = 8'd0;
  logic        flagM = 1'b1;
  logic        flagX = 1'b1;
  logic        reqReady, memRead, memWrite, done, flagN, flagZ;
  logic [23:0] memAddr;
  logic [7:0]  memWdata, memRdata;
  logic [1:0]  extraCycles;
  logic [15:0] regA, regX, regY;

  logic [7:0]  mem [256];
  logic [23:0] logAddr [256];
  logic [7:0]  logData [256];
  logic        logWr [256];
  int          logN = 0;
  int          errors = 0;
  int          checks = 0;
  int          beats, lat, startN;

  always #10 clk = ~clk;

  ldst_unit uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqMode(reqMode),
    .reqAddr(reqAddr), .pageCross(pageCross), .dpLow(dpLow), .flagM(flagM), .flagX(flagX),
    .reqReady(reqReady), .memAddr(memAddr), .memRead(memRead), .memWrite(memWrite),
    .memWdata(memWdata), .memRdata(memRdata), .done(done), .extraCycles(extraCycles),
    .regA(regA), .regX(regX), .regY(regY), .flagN(flagN), .flagZ(flagZ)
  );

  assign memRdata = mem[memAddr[7:0]];

  always @(posedge clk) begin
    if (memRead || memWrite) begin
      logAddr[logN[7:0]] <= memAddr;
      logData[logN[7:0]] <= memWrite ? memWdata : memRdata;
      logWr[logN[7:0]]   <= memWrite;
      logN <= logN + 1;
    end
    if (memWrite) mem[memAddr[7:0]] <= memWdata;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [2:0] op, input logic [3:0] mode, input logic [23:0] addr,
                       input logic m, input logic x, input logic [7:0] dp, input logic pc);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqMode = mode; reqAddr = addr;
    flagM = m; flagX = x; dpLow = dp; pageCross = pc;
    startN = logN;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!done && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    beats = logN - startN;
  endtask

  task automatic expectBeat(input string tag, input int idx, input logic wr,
                            input logic [23:0] addr, input logic [7:0] data);
    chk({tag, " beat kind"}, 32'(logWr[(startN + idx) % 256]), 32'(wr));
    chk({tag, " beat addr"}, 32'(logAddr[(startN + idx) % 256]), 32'(addr));
    chk({tag, " beat data"}, 32'(logData[(startN + idx) % 256]), 32'(data));
  endtask

  task automatic testReset();
    chk("R12 reset ready", 32'(reqReady), 1);
    chk("R12 reset done", 32'(done), 0);
    chk("R12 reset regs", {regA, regX}, 32'h0);
    chk("R12 reset regY", 32'(regY), 0);
  endtask

  task automatic testWideLoadA();
    mem[8'h10] = 8'h34; mem[8'h11] = 8'h82;
    runOp(LDA, M_ABS, 24'h000010, 1'b0, 1'b1, 8'h00, 1'b0);
    chk("R1 wide A beats", 32'(beats), 2);
    chk("R12 wide latency", 32'(lat), 3);
    expectBeat("R3 lo", 0, 1'b0, 24'h000010, 8'h34);
    expectBeat("R3 hi", 1, 1'b0, 24'h000011, 8'h82);
    chk("R1 wide A value", 32'(regA), 32'h8234);
    chk("R10 N wide", 32'(flagN), 1);
    chk("R9 Z wide", 32'(flagZ), 0);
    chk("R5 base wide", 32'(extraCycles), 1);
  endtask

  task automatic testNarrowLoadA();
    mem[8'h20] = 8'h00;
    runOp(LDA, M_ABS, 24'h000020, 1'b1, 1'b0, 8'h00, 1'b0);
    chk("R1 narrow A beats", 32'(beats), 1);
    chk("R12 narrow latency", 32'(lat), 2);
    chk("R11 high byte kept", 32'(regA), 32'h8200);
    chk("R9 Z narrow", 32'(flagZ), 1);
    chk("R10 N narrow", 32'(flagN), 0);
    chk("R5 base narrow", 32'(extraCycles), 0);
  endtask

  task automatic testIndexLoads();
    mem[8'h30] = 8'h5A; mem[8'h31] = 8'hC3;
    runOp(LDX, M_ABS_Y, 24'h000030, 1'b1, 1'b0, 8'h00, 1'b1);
    chk("R2 wide X beats", 32'(beats), 2);
    chk("R2 X value", 32'(regX), 32'hC35A);
    chk("R7 X abs-Y cross", 32'(extraCycles), 2);
    runOp(LDX, M_ABS_X, 24'h000030, 1'b1, 1'b0, 8'h00, 1'b1);
    chk("R7 X abs-X no cross penalty", 32'(extraCycles), 1);
    mem[8'h40] = 8'h80;
    runOp(LDY, M_DP, 24'h000040, 1'b0, 1'b1, 8'h05, 1'b0);
    chk("R2 narrow Y beats", 32'(beats), 1);
    chk("R11 Y value", 32'(regY), 32'h0080);
    chk("R10 N bit7", 32'(flagN), 1);
    chk("R6 Y dp penalty", 32'(extraCycles), 1);
  endtask

  task automatic testLoadFlagsAndPenalties();
    mem[8'h50] = 8'h00; mem[8'h51] = 8'h01;
    runOp(LDA, M_DP, 24'h000050, 1'b0, 1'b1, 8'h00, 1'b0);
    chk("R9 wide nonzero hi", 32'(flagZ), 0);
    chk("R10 N clear", 32'(flagN), 0);
    chk("R6 dp zero no penalty", 32'(extraCycles), 1);
    runOp(LDA, M_ABS_X, 24'h000050, 1'b1, 1'b1, 8'h07, 1'b1);
    chk("R7 A abs-X cross", 32'(extraCycles), 1);
    chk("R11 narrow keeps hi", 32'(regA), 32'h0100);
    runOp(LDA, M_DP, 24'h000050, 1'b1, 1'b1, 8'h07, 1'b1);
    chk("R6 A dp penalty", 32'(extraCycles), 1);
  endtask

  task automatic testStores();
    logic [15:0] a0, x0, y0;
    mem[8'h50] = 8'h00; mem[8'h51] = 8'h01;
    runOp(LDA, M_ABS, 24'h000050, 1'b0, 1'b1, 8'h00, 1'b0);
    a0 = regA; x0 = regX; y0 = regY;
    runOp(STA, M_DP, 24'hFFFFFF, 1'b0, 1'b1, 8'h01, 1'b0);
    chk("R1 wide store beats", 32'(beats), 2);
    expectBeat("R3 wrap lo", 0, 1'b1, 24'hFFFFFF, 8'h00);
    expectBeat("R3 wrap hi", 1, 1'b1, 24'h000000, 8'h01);
    chk("R6 STA dp", 32'(extraCycles), 2);
    chk("R13 regs kept", {regA, regX}, {a0, x0});
    chk("R13 regY kept", 32'(regY), 32'(y0));
    runOp(STX, M_ABS, 24'h000060, 1'b0, 1'b1, 8'h09, 1'b0);
    chk("R2 narrow STX beats", 32'(beats), 1);
    expectBeat("R4 STX lo", 0, 1'b1, 24'h000060, 8'h5A);
    chk("R8 STX absolute exempt", 32'(extraCycles), 0);
    runOp(STY, M_DP_Y, 24'h000070, 1'b1, 1'b0, 8'h09, 1'b0);
    expectBeat("R4 STY lo", 0, 1'b1, 24'h000070, 8'h80);
    expectBeat("R4 STY hi", 1, 1'b1, 24'h000071, 8'h00);
    chk("R8 STY dp", 32'(extraCycles), 2);
  endtask

  task automatic testStoreZero();
    mem[8'h80] = 8'hFF; mem[8'h81] = 8'hFF; mem[8'h82] = 8'hEE;
    runOp(STZ, M_ABS_X, 24'h000080, 1'b0, 1'b0, 8'h01, 1'b0);
    chk("R4 STZ wide beats", 32'(beats), 2);
    expectBeat("R4 STZ lo", 0, 1'b1, 24'h000080, 8'h00);
    expectBeat("R4 STZ hi", 1, 1'b1, 24'h000081, 8'h00);
    chk("R8 STZ abs-X exempt", 32'(extraCycles), 1);
    runOp(STZ, M_DP, 24'h000082, 1'b1, 1'b0, 8'h02, 1'b0);
    chk("R4 STZ narrow beats", 32'(beats), 1);
    chk("R4 STZ narrow zero", 32'(mem[8'h82]), 0);
    chk("R8 STZ dp penalty", 32'(extraCycles), 1);
  endtask

  task automatic testBusyIgnored();
    int wrCount;
    mem[8'h90] = 8'h11;
    @(negedge clk);
    reqValid = 1'b1; reqOp = LDA; reqMode = M_ABS; reqAddr = 24'h000090;
    flagM = 1'b1; flagX = 1'b1; dpLow = 8'h00; pageCross = 1'b0;
    startN = logN;
    @(negedge clk);
    reqOp = STZ; reqAddr = 24'h0000A0;
    chk("R12 busy not ready", 32'(reqReady), 0);
    @(negedge clk);
    chk("R12 done one beat later", 32'(done), 1);
    reqValid = 1'b0;
    @(negedge clk);
    chk("R12 done single pulse", 32'(done), 0);
    chk("R12 ready again", 32'(reqReady), 1);
    @(negedge clk);
    beats = logN - startN;
    wrCount = 0;
    for (int i = 0; i < beats; i++) wrCount += int'(logWr[(startN + i) % 256]);
    chk("R12 busy request ignored beats", 32'(beats), 1);
    chk("R12 busy request no write", 32'(wrCount), 0);
    chk("R11 A low updated", 32'(regA[7:0]), 32'h11);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testWideLoadA();
    testNarrowLoadA();
    testIndexLoads();
    testLoadFlagsAndPenalties();
    testStores();
    testStoreZero();
    testBusyIgnored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule